// File: doc/BRIEF.md
# Audio Master Clock Ratio Generator

This block turns a master clock into the two timing clocks of a stereo serial audio port: a bit clock running at 64 times the sample rate and a frame clock running at the sample rate. A two-bit ratio code states how many master-clock cycles make up one sample period (128, 256, 384 or 512). The block divides accordingly, including the non-power-of-two 384 setting. Both outputs have a 50% duty cycle, and every frame clock edge falls on a falling bit clock edge.

A two-bit speed code names the sampling band: normal, double or quad. The three legal bands share the same dividers, because the band follows from the master clock rate. The fourth code is illegal. It raises an error flag and silences both clocks. The clocks are driven only in master mode while powered up; in slave mode or power-down both outputs stay low. A change of the ratio code restarts both dividers from phase zero. Moving between legal speed codes at a fixed ratio leaves the running phase untouched.

Top module: `audio_clkgen`

## Requirements
- R1: The bit clock half period, in master-clock cycles, is 2 for ratio code 00, 1 for 01, 4 for 10 and 3 for 11. One frame therefore spans 256, 128, 512 and 384 master-clock cycles respectively.
- R2: The bit clock has equal high and low times. The frame clock is high for 32 bit clock periods, then low for 32, giving 64 bit clock periods per frame.
- R3: The frame clock changes only in the cycle in which the bit clock falls. After a start, the bit clock goes high first, after one half period. The frame clock first rises together with the 32nd falling bit clock edge.
- R4: When master_en is 0 (slave mode), bclk_o and fclk_o are held at 0.
- R5: When pwr_up is 0, bclk_o and fclk_o are held at 0. On power-up both dividers start from phase zero: the bit clock goes high after one half period, and the frame clock goes high after 64 half periods.
- R6: Speed codes 00, 01 and 10 are legal and give identical clocks. Switching between them while running does not disturb the bit clock phase.
- R7: speed_err_o is 1 one cycle after speed code 11 is applied and 0 one cycle after any legal code. While the code is 11, both clocks are held at 0.
- R8: At the first master-clock edge after the ratio code changes, both clocks go to 0 and the dividers restart. The bit clock then rises one new half period later, and the frame clock rises 64 new half periods after the restart edge.
- R9: While rst_n is 0, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up | input | 1 | 1 = powered up, 0 = powered down |
| master_en | input | 1 | 1 = master mode (clocks driven), 0 = slave mode |
| ratio_sel | input | 2 | Master-clock-to-sample-rate ratio code |
| speed_sel | input | 2 | Sampling speed band code |
| bclk_o | output | 1 | Bit clock, 64 times the sample rate |
| fclk_o | output | 1 | Frame clock, at the sample rate |
| speed_err_o | output | 1 | Illegal speed code flag |

## Verification
The hardest case to reach is a ratio change that lands mid-frame, while both clocks are high. To get there, the stimulus runs at the 512 ratio and polls the outputs until both are high. It then switches to the 128 ratio on the next falling master-clock edge. The restart timing is measured from that edge. The phase-continuity case is handled the same way: the stimulus waits for an observed bit clock rise before it changes the speed code.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    typedef enum logic [1:0] {
        RATIO_256 = 2'b00,
        RATIO_128 = 2'b01,
        RATIO_512 = 2'b10,
        RATIO_384 = 2'b11
    } ratio_e;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_BAD    = 2'b11
    } speed_e;

    // Master-clock cycles per sample period for a ratio code
    function automatic int mclk_per_frame(input logic [1:0] code);
        case (code)
            RATIO_256: return 256;
            RATIO_128: return 128;
            RATIO_512: return 512;
            default:   return 384;
        endcase
    endfunction

endpackage

// File: rtl/clkgen_ratio_track.sv
module clkgen_ratio_track
    import clkgen_pkg::*;
#(
    parameter int FRAME_BITS = 64,
    parameter int MCNT_W     = 3
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic [1:0]        ratio_sel,
    output logic              restart_o,
    output logic [MCNT_W-1:0] half_o
);
    typedef struct packed {
        logic [1:0] ratio;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.ratio = ratio_sel;
        restart_o  = (ratio_sel != st_q.ratio);
        half_o     = MCNT_W'(mclk_per_frame(ratio_sel) / (2 * FRAME_BITS));
    end

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/clkgen_bit_div.sv
module clkgen_bit_div #(
    parameter int MCNT_W = 3
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              restart_i,
    input  logic [MCNT_W-1:0] half_i,
    output logic              bclk_o,
    output logic              fall_o
);
    typedef struct packed {
        logic [MCNT_W-1:0] mcnt;
        logic              bclk;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        fall_o = 1'b0;
        if (!run_i || restart_i) begin
            st_d.mcnt = '0;
            st_d.bclk = 1'b0;
        end else if (st_q.mcnt == half_i - MCNT_W'(1)) begin
            st_d.mcnt = '0;
            st_d.bclk = ~st_q.bclk;
            fall_o    = st_q.bclk;
        end else begin
            st_d.mcnt = st_q.mcnt + MCNT_W'(1);
        end
    end

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_o = st_q.bclk;
endmodule

// File: rtl/clkgen_frame_div.sv
module clkgen_frame_div #(
    parameter int FRAME_BITS = 64
) (
    input  logic mclk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    input  logic fall_i,
    output logic fclk_o
);
    localparam int HALF_FRAME = FRAME_BITS / 2;
    localparam int FCNT_W     = $clog2(HALF_FRAME);

    typedef struct packed {
        logic [FCNT_W-1:0] fcnt;
        logic              fclk;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i || restart_i) begin
            st_d.fcnt = '0;
            st_d.fclk = 1'b0;
        end else if (fall_i) begin
            if (st_q.fcnt == FCNT_W'(HALF_FRAME - 1)) begin
                st_d.fcnt = '0;
                st_d.fclk = ~st_q.fclk;
            end else begin
                st_d.fcnt = st_q.fcnt + FCNT_W'(1);
            end
        end
    end

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fclk_o = st_q.fclk;
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import clkgen_pkg::*;
#(
    parameter int FRAME_BITS = 64,
    parameter int MCNT_W     = 3
) (
    input  logic       mclk,
    input  logic       rst_n,
    input  logic       pwr_up,
    input  logic       master_en,
    input  logic [1:0] ratio_sel,
    input  logic [1:0] speed_sel,
    output logic       bclk_o,
    output logic       fclk_o,
    output logic       speed_err_o
);
    typedef struct packed {
        logic err;
    } state_t;

    state_t            st_d, st_q;
    logic              speed_bad;
    logic              run;
    logic              restart;
    logic              fall;
    logic [MCNT_W-1:0] half;

    always_comb begin
        speed_bad = (speed_sel == SPD_BAD);
        run       = pwr_up && master_en && !speed_bad;
        st_d      = st_q;
        st_d.err  = speed_bad;
    end

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign speed_err_o = st_q.err;

    clkgen_ratio_track #(
        .FRAME_BITS (FRAME_BITS),
        .MCNT_W     (MCNT_W)
    ) u_ratio (
        .mclk      (mclk),
        .rst_n     (rst_n),
        .ratio_sel (ratio_sel),
        .restart_o (restart),
        .half_o    (half)
    );

    clkgen_bit_div #(
        .MCNT_W (MCNT_W)
    ) u_bit (
        .mclk      (mclk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (restart),
        .half_i    (half),
        .bclk_o    (bclk_o),
        .fall_o    (fall)
    );

    clkgen_frame_div #(
        .FRAME_BITS (FRAME_BITS)
    ) u_frame (
        .mclk      (mclk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (restart),
        .fall_i    (fall),
        .fclk_o    (fclk_o)
    );
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
    input logic       mclk,
    input logic       rst_n,
    input logic       pwr_up,
    input logic       master_en,
    input logic [1:0] ratio_sel,
    input logic [1:0] speed_sel,
    input logic       bclk_o,
    input logic       fclk_o,
    input logic       speed_err_o
);
    // R4: slave mode silences both clocks
    p_slave_quiet_r4: assert property (@(posedge mclk) disable iff (!rst_n)
        !master_en |=> (!bclk_o && !fclk_o));

    // R5: power-down silences both clocks
    p_down_quiet_r5: assert property (@(posedge mclk) disable iff (!rst_n)
        !pwr_up |=> (!bclk_o && !fclk_o));

    // R7: error flag follows the illegal speed code
    p_err_set_r7: assert property (@(posedge mclk) disable iff (!rst_n)
        (speed_sel == 2'b11) |=> (speed_err_o && !bclk_o && !fclk_o));

    p_err_clear_r7: assert property (@(posedge mclk) disable iff (!rst_n)
        (speed_sel != 2'b11) |=> !speed_err_o);

    // R3: frame clock rises only with a falling bit clock
    p_fclk_on_bfall_r3: assert property (@(posedge mclk) disable iff (!rst_n)
        $rose(fclk_o) |-> $fell(bclk_o));

    // R8: ratio change forces both clocks low
    p_restart_quiet_r8: assert property (@(posedge mclk) disable iff (!rst_n)
        (ratio_sel != $past(ratio_sel)) |=> (!bclk_o && !fclk_o));
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (.*);

// File: tb/audio_clkgen_bench.sv
module audio_clkgen_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pwr_up;
    logic       master_en;
    logic [1:0] ratio_sel;
    logic [1:0] speed_sel;
    logic       bclk;
    logic       fclk;
    logic       err;

    int checks   = 0;
    int failures = 0;
    int pushed   = 0;
    int mon_done = 0;
    bit finished = 1'b0;

    typedef struct {
        int    half;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    audio_clkgen u_audio_clkgen (
        .mclk        (clk),
        .rst_n       (rst_n),
        .pwr_up      (pwr_up),
        .master_en   (master_en),
        .ratio_sel   (ratio_sel),
        .speed_sel   (speed_sel),
        .bclk_o      (bclk),
        .fclk_o      (fclk),
        .speed_err_o (err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sample one time unit after the active edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input bit pu, input bit me, input logic [1:0] r, input logic [1:0] s);
        @(negedge clk);
        pwr_up    = pu;
        master_en = me;
        ratio_sel = r;
        speed_sel = s;
    endtask

    task automatic push_shape(input int h, input string tag);
        exp_t e;
        e.half = h;
        e.tag  = tag;
        sb_q.push_back(e);
        pushed++;
        wait (mon_done == pushed);
    endtask

    task automatic hold_low(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (bclk || fclk) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    // Monitor: measures one full frame and compares with the expected shape
    initial begin
        forever begin
            exp_t e;
            bit   pb, pf;
            int   fhi, flo, rises, run_len, lo, hi;
            wait (sb_q.size() > 0);
            e = sb_q.pop_front();
            step();
            pf = fclk;
            step();
            while (!( !pf && fclk)) begin
                pf = fclk;
                step();
            end
            chk(bclk == 1'b0, {e.tag, " R3 bclk low at fclk rise"}, int'(bclk), 0);
            fhi = 0; rises = 0; run_len = 0; lo = -1; hi = -1; pb = bclk;
            while (fclk) begin
                fhi++;
                if (bclk != pb) begin
                    if (!pb && lo < 0) lo = run_len;
                    else if (pb && hi < 0 && lo >= 0) hi = run_len;
                    if (bclk) rises++;
                    run_len = 0;
                end
                run_len++;
                pb = bclk;
                step();
            end
            flo = 0;
            while (!fclk) begin
                flo++;
                step();
            end
            chk(lo == e.half, {e.tag, " bclk low time"}, lo, e.half);
            chk(hi == e.half, {e.tag, " bclk high time"}, hi, e.half);
            chk(rises == 32, {e.tag, " R2 bclk periods per fclk half"}, rises, 32);
            chk(fhi == 64 * e.half, {e.tag, " R2 fclk high time"}, fhi, 64 * e.half);
            chk(flo == 64 * e.half, {e.tag, " R2 fclk low time"}, flo, 64 * e.half);
            mon_done++;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL timeout (all requirements) actual=%0d expected=%0d", 150000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int  n;
        bit  seen;
        rst_n     = 1'b0;
        pwr_up    = 1'b0;
        master_en = 1'b1;
        ratio_sel = 2'b00;
        speed_sel = 2'b00;
        repeat (3) step();
        chk(!bclk && !fclk && !err, "R9 reset outputs", {29'd0, bclk, fclk, err}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: powered down keeps clocks low
        hold_low(300, "R5 powered down");

        // R5/R3: start from phase zero on power-up, ratio 00
        drive(1'b1, 1'b1, 2'b00, 2'b00);
        n = 0;
        do begin step(); n++; end while (!bclk && n < 1000);
        chk(n == 2, "R5 first bclk rise sample", n, 2);
        do begin step(); n++; end while (!fclk && n < 1000);
        chk(n == 128, "R3 first fclk rise sample", n, 128);

        // R1/R2: all four ratio codes
        push_shape(2, "R1 ratio 00");
        drive(1'b1, 1'b1, 2'b01, 2'b00);
        push_shape(1, "R1 ratio 01");
        drive(1'b1, 1'b1, 2'b10, 2'b00);
        push_shape(4, "R1 ratio 10");
        drive(1'b1, 1'b1, 2'b11, 2'b00);
        push_shape(3, "R1 ratio 11");

        // R6: legal speed codes give the same clocks
        drive(1'b1, 1'b1, 2'b11, 2'b01);
        push_shape(3, "R6 speed 01");
        drive(1'b1, 1'b1, 2'b11, 2'b10);
        push_shape(3, "R6 speed 10");
        chk(err == 1'b0, "R7 no error on legal code", int'(err), 0);

        // R6: speed switch keeps bclk phase (ratio 00, half period 2)
        drive(1'b1, 1'b1, 2'b00, 2'b00);
        repeat (4) step();
        seen = bclk;
        step();
        while (!( !seen && bclk)) begin
            seen = bclk;
            step();
        end
        @(negedge clk);
        speed_sel = 2'b01;
        step(); chk(bclk == 1'b1, "R6 phase sample 1", int'(bclk), 1);
        step(); chk(bclk == 1'b0, "R6 phase sample 2", int'(bclk), 0);
        step(); chk(bclk == 1'b0, "R6 phase sample 3", int'(bclk), 0);
        step(); chk(bclk == 1'b1, "R6 phase sample 4", int'(bclk), 1);

        // R7: illegal speed code
        drive(1'b1, 1'b1, 2'b00, 2'b11);
        step();
        chk(err == 1'b1, "R7 error flag set", int'(err), 1);
        hold_low(200, "R7 clocks held low");
        drive(1'b1, 1'b1, 2'b00, 2'b00);
        step();
        chk(err == 1'b0, "R7 error flag cleared", int'(err), 0);

        // R4: slave mode
        drive(1'b1, 1'b0, 2'b00, 2'b00);
        hold_low(300, "R4 slave mode");

        // R8: ratio change mid-frame while both clocks high
        drive(1'b1, 1'b1, 2'b10, 2'b00);
        n = 0;
        do begin step(); n++; end while (!(bclk && fclk) && n < 2000);
        chk(bclk && fclk, "R8 reached both-high state", {30'd0, bclk, fclk}, 3);
        @(negedge clk);
        ratio_sel = 2'b01;
        step();
        chk(!bclk && !fclk, "R8 clocks low at restart", {30'd0, bclk, fclk}, 0);
        step();
        chk(bclk == 1'b1, "R8 bclk rises one half period later", int'(bclk), 1);
        n = 2;
        while (!fclk && n < 1000) begin step(); n++; end
        chk(n == 65, "R8 first fclk rise after restart", n, 65);
        push_shape(1, "R8 shape after restart");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule